// File: doc/BRIEF.md
# Sector Single-Bit ECC Engine

This block sits beside the data path of a NAND flash controller. It watches every byte of one 512-byte data step and folds it into a 32-bit parity word. The code is built from position parities. Each data bit has a 12-bit position number, made of the byte index times eight plus the bit number. For every position bit there are two parity bits: one covers the data bits whose position has that bit set, and the other covers the data bits whose position has it clear. A single flipped data bit therefore leaves a syndrome in which every pair is complementary, and that pattern spells out the position of the flip.

Software opens a step with a one-cycle init pulse, which clears the accumulator and the byte counter. It can hold the accumulator still with a lock level, for example while spare-area bytes pass on the same bus. When writing, software reads the parity word and stores it. When reading, software feeds the same bytes through the engine, then hands the stored parity back as two 16-bit halves. One cycle after the second half is written, the engine presents an 18-bit status word. That word gives a 2-bit verdict and, for a correctable error, the byte index and bit index of the bad bit.

Top module: `nand_secc_engine`

## Requirements
- R1: After reset, `parity_word` is 0, `stat_valid` is 0 and `stat_word` is 0.
- R2: An `ecc_init` pulse clears the parity word and the byte counter on the next clock edge. A byte offered in the same cycle as init is dropped.
- R3: While `ecc_lock` is 1, offered bytes change neither the parity word nor the byte counter. Bytes offered after lock returns to 0 continue at the byte index where the step stopped.
- R4: Each accepted byte with counter value A is folded in as follows. For each data bit c that is 1, take the position p = A*8 + c. Then, for every k from 0 to 11, toggle parity bit 2k if bit k of p is 1, and toggle parity bit 2k+1 if it is 0. Bits 31:24 stay 0. The counter is 9 bits wide and wraps after 512 bytes.
- R5: A write on `cmp_lo_wr` stores `cmp_half` as stored parity bytes 0 and 1, which are bits 15:0 of the stored word. A write on `cmp_hi_wr` supplies bytes 2 and 3, which are bits 31:16. The syndrome is the stored word XOR the current parity word. On the clock after a high-half write, `stat_valid` is 1 and `stat_word` holds the verdict. A low-half write or an init returns `stat_valid` to 0.
- R6: A zero syndrome gives status code 0 and `stat_word` equal to 0.
- R7: A syndrome that is complementary in all twelve pairs and has bits 31:24 clear is reported as code 1. Its position p is read from the even syndrome bits. The status word then holds the code in bits 1:0, 0 in bits 3:2, p mod 8 in bits 6:4, and p/8 in bits 17:7.
- R8: A syndrome with exactly one bit set is an error in the stored parity itself and gives code 3, with all location bits 0.
- R9: Any other nonzero syndrome gives code 2, with all location bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_init | input | 1 | One-cycle pulse; starts a new step |
| ecc_lock | input | 1 | Level; holds the accumulator |
| byte_vld | input | 1 | A data byte is present on `byte_data` |
| byte_data | input | 8 | Data byte of the step |
| cmp_lo_wr | input | 1 | Write stored parity bytes 0..1 |
| cmp_hi_wr | input | 1 | Write stored parity bytes 2..3 and start the compare |
| cmp_half | input | 16 | Stored parity half; the lower byte is the earlier parity byte |
| parity_word | output | 32 | Computed parity; bits 7:0 are parity byte 0 |
| stat_word | output | 18 | Verdict: code in 1:0, bit index in 6:4, byte index in 17:7 |
| stat_valid | output | 1 | `stat_word` belongs to the last compare |

## Verification
Any corruption of the accumulator or of the byte counter shows on `parity_word` at the next clock edge. A counter that is off by one byte spreads into a whole row of wrong parity bits, not a single one. The bench therefore compares the parity word with a bit-level position model on every cycle, over gaps, locks, init collisions and the 512-byte wrap. A wrong stored half or a wrong decode shows in `stat_word` one cycle after the high-half write. Directed flips at the first byte, at an interior byte and at the last byte check each location field at its edges.

// File: rtl/secc_pkg.sv
package secc_pkg;
  localparam int BYTE_W     = 8;
  localparam int COL_W      = $clog2(BYTE_W);
  localparam int STEP_BYTES = 512;
  localparam int ADDR_W     = $clog2(STEP_BYTES);
  localparam int POS_W      = ADDR_W + COL_W;
  localparam int PAR_W      = 32;
  localparam int HALF_W     = PAR_W / 2;
  localparam int LOC_W      = 11;
  localparam int BYTE_LSB   = 7;
  localparam int BIT_LSB    = 4;
  localparam int STAT_W     = BYTE_LSB + LOC_W;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_MULTI = 2'd2,
    ST_PARITY = 2'd3
  } stat_code_t;

  // Mask of the bit lanes within a byte whose lane number has bit k set.
  function automatic logic [BYTE_W-1:0] lane_mask(input int k);
    logic [BYTE_W-1:0] m;
    for (int j = 0; j < BYTE_W; j++) m[j] = 1'((j >> k) & 1);
    return m;
  endfunction

  // Fold one data byte at byte index idx into the accumulator.
  function automatic logic [PAR_W-1:0] fold_byte(input logic [PAR_W-1:0] acc,
                                                 input logic [ADDR_W-1:0] idx,
                                                 input logic [BYTE_W-1:0] d);
    logic [PAR_W-1:0] r;
    logic whole;
    r = acc;
    for (int k = 0; k < COL_W; k++) begin
      r[2*k]   = r[2*k]   ^ (^(d & lane_mask(k)));
      r[2*k+1] = r[2*k+1] ^ (^(d & ~lane_mask(k)));
    end
    whole = ^d;
    for (int a = 0; a < ADDR_W; a++) begin
      if (idx[a]) r[2*(a+COL_W)]   = r[2*(a+COL_W)] ^ whole;
      else        r[2*(a+COL_W)+1] = r[2*(a+COL_W)+1] ^ whole;
    end
    return r;
  endfunction

  // Turn a syndrome into the packed status word.
  function automatic logic [STAT_W-1:0] classify(input logic [PAR_W-1:0] s);
    logic [STAT_W-1:0] st;
    logic [POS_W-1:0] pos;
    logic pairs_ok;
    st = '0;
    pos = '0;
    pairs_ok = (s[PAR_W-1:2*POS_W] == '0);
    for (int k = 0; k < POS_W; k++) begin
      if (s[2*k] == s[2*k+1]) pairs_ok = 1'b0;
      pos[k] = s[2*k];
    end
    if (s == '0) begin
      st[1:0] = ST_CLEAN;
    end else if ($countones(s) == 1) begin
      st[1:0] = ST_PARITY;
    end else if (pairs_ok) begin
      st[1:0] = ST_FIXED;
      st[BIT_LSB +: COL_W]   = pos[COL_W-1:0];
      st[BYTE_LSB +: ADDR_W] = pos[POS_W-1:COL_W];
    end else begin
      st[1:0] = ST_MULTI;
    end
    return st;
  endfunction
endpackage

// File: rtl/secc_accum.sv
module secc_accum
  import secc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_init,
  input  logic              ecc_lock,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [PAR_W-1:0]  acc_q,
  output logic [ADDR_W-1:0] idx_q,
  output logic              take
);
  assign take = byte_vld & ~ecc_lock & ~ecc_init;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (ecc_init) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (take) begin
      acc_q <= fold_byte(acc_q, idx_q, byte_data);
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/secc_decode.sv
module secc_decode
  import secc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_init,
  input  logic              cmp_lo_wr,
  input  logic              cmp_hi_wr,
  input  logic [HALF_W-1:0] cmp_half,
  input  logic [PAR_W-1:0]  acc_q,
  output logic [PAR_W-1:0]  syn_q,
  output logic [STAT_W-1:0] stat_q,
  output logic              valid_q
);
  logic [HALF_W-1:0] low_q;
  logic [PAR_W-1:0]  syn_d;

  assign syn_d = {cmp_half, low_q} ^ acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q   <= '0;
      syn_q   <= '0;
      stat_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (cmp_lo_wr) low_q <= cmp_half;
      if (ecc_init) begin
        stat_q  <= '0;
        valid_q <= 1'b0;
      end else if (cmp_hi_wr) begin
        syn_q   <= syn_d;
        stat_q  <= classify(syn_d);
        valid_q <= 1'b1;
      end else if (cmp_lo_wr) begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nand_secc_engine.sv
module nand_secc_engine
  import secc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_init,
  input  logic              ecc_lock,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              cmp_lo_wr,
  input  logic              cmp_hi_wr,
  input  logic [HALF_W-1:0] cmp_half,
  output logic [PAR_W-1:0]  parity_word,
  output logic [STAT_W-1:0] stat_word,
  output logic              stat_valid
);
  logic              byte_take;
  logic [ADDR_W-1:0] byte_idx;
  logic [PAR_W-1:0]  syn_word;

  secc_accum u_acc (
    .clk(clk), .rst_n(rst_n), .ecc_init(ecc_init), .ecc_lock(ecc_lock),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .acc_q(parity_word), .idx_q(byte_idx), .take(byte_take)
  );

  secc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ecc_init(ecc_init),
    .cmp_lo_wr(cmp_lo_wr), .cmp_hi_wr(cmp_hi_wr), .cmp_half(cmp_half),
    .acc_q(parity_word), .syn_q(syn_word), .stat_q(stat_word), .valid_q(stat_valid)
  );
endmodule

// File: rtl/nand_secc_checker.sv
module nand_secc_checker
  import secc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ecc_init,
  input logic              ecc_lock,
  input logic              cmp_hi_wr,
  input logic [PAR_W-1:0]  parity_word,
  input logic [STAT_W-1:0] stat_word,
  input logic              stat_valid,
  input logic [ADDR_W-1:0] byte_idx,
  input logic [PAR_W-1:0]  syn_word
);
  assert_init_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_init |=> (parity_word == '0 && byte_idx == '0));

  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_lock && !ecc_init) |=> ($stable(parity_word) && $stable(byte_idx)));

  assert_top_byte_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    parity_word[PAR_W-1:2*POS_W] == '0);

  assert_valid_after_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_valid) |-> $past(cmp_hi_wr));

  assert_hi_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hi_wr && !ecc_init) |=> stat_valid);

  assert_clean_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[1:0] == 2'd0) |-> stat_word == '0);

  assert_fixed_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[1:0] == 2'd1) |->
      ($countones(syn_word) == POS_W && stat_word[3:2] == 2'b00 &&
       stat_word[STAT_W-1:BYTE_LSB+ADDR_W] == '0));

  assert_parity_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[1:0] == 2'd3) |->
      ($countones(syn_word) == 1 && stat_word[STAT_W-1:2] == '0));

  assert_multi_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && stat_word[1:0] == 2'd2) |-> stat_word[STAT_W-1:2] == '0);
endmodule

bind nand_secc_engine nand_secc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ecc_init(ecc_init), .ecc_lock(ecc_lock),
  .cmp_hi_wr(cmp_hi_wr), .parity_word(parity_word), .stat_word(stat_word),
  .stat_valid(stat_valid), .byte_idx(byte_idx), .syn_word(syn_word)
);

// File: tb/sim_nand_secc_engine.sv
module sim_nand_secc_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ecc_init = 1'b0, ecc_lock = 1'b0, byte_vld = 1'b0;
  logic [7:0] byte_data = '0;
  logic cmp_lo_wr = 1'b0, cmp_hi_wr = 1'b0;
  logic [15:0] cmp_half = '0;
  logic [31:0] parity_word;
  logic [17:0] stat_word;
  logic stat_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  nand_secc_engine u0 (
    .clk(clk), .rst_n(rst_n), .ecc_init(ecc_init), .ecc_lock(ecc_lock),
    .byte_vld(byte_vld), .byte_data(byte_data), .cmp_lo_wr(cmp_lo_wr),
    .cmp_hi_wr(cmp_hi_wr), .cmp_half(cmp_half), .parity_word(parity_word),
    .stat_word(stat_word), .stat_valid(stat_valid)
  );

  // Reference decode, written from the requirements (R6..R9).
  function automatic logic [17:0] ref_class(input logic [31:0] s);
    int n = 0;
    int pos = 0;
    bit ok;
    for (int i = 0; i < 32; i++) n += int'(s[i]);
    if (n == 0) return 18'd0;
    if (n == 1) return 18'd3;
    ok = (s[31:24] == 8'h00);
    for (int k = 0; k < 12; k++) begin
      if (s[2*k] == s[2*k+1]) ok = 0;
      else if (s[2*k]) pos += (1 << k);
    end
    if (ok) return 18'(((pos / 8) << 7) | ((pos % 8) << 4) | 1);
    return 18'd2;
  endfunction

  // Behavioural reference model, updated on every clock.
  logic [31:0] m_par;
  int m_idx;
  logic [15:0] m_low;
  logic [17:0] m_stat;
  bit m_valid;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_par = '0; m_idx = 0; m_low = '0; m_stat = '0; m_valid = 0;
    end else begin
      if (ecc_init) begin
        m_valid = 0; m_stat = '0;
      end else if (cmp_hi_wr) begin
        m_stat = ref_class({cmp_half, m_low} ^ m_par); m_valid = 1;
      end else if (cmp_lo_wr) begin
        m_valid = 0;
      end
      if (cmp_lo_wr) m_low = cmp_half;
      if (ecc_init) begin
        m_par = '0; m_idx = 0;
      end else if (byte_vld && !ecc_lock) begin
        for (int c = 0; c < 8; c++) begin
          if (byte_data[c]) begin
            int p;
            p = m_idx * 8 + c;
            for (int k = 0; k < 12; k++) begin
              if ((p >> k) & 1) m_par[2*k] = ~m_par[2*k];
              else m_par[2*k+1] = ~m_par[2*k+1];
            end
          end
        end
        m_idx = (m_idx + 1) % 512;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(parity_word == m_par, "R4 parity vs model", parity_word, m_par);
      chk(stat_valid == m_valid, "R5 valid vs model", 32'(stat_valid), 32'(m_valid));
      if (m_valid) chk(stat_word == m_stat, "R7 status vs model", 32'(stat_word), 32'(m_stat));
    end
  end

  function automatic logic [7:0] gen(input int i, input int seed);
    return 8'((i * seed * 13) + (i >> 3) + seed * 7);
  endfunction

  task automatic feed(input int first, input int n, input int seed,
                      input int fb1, input int fbit1, input int fb2, input int fbit2,
                      input bit gaps);
    for (int i = first; i < first + n; i++) begin
      logic [7:0] d;
      d = gen(i, seed);
      if (i == fb1) d = d ^ 8'(1 << fbit1);
      if (i == fb2) d = d ^ 8'(1 << fbit2);
      if (gaps && (i % 5 == 0)) begin
        @(negedge clk); byte_vld = 1'b0;
      end
      @(negedge clk); byte_vld = 1'b1; byte_data = d;
    end
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic pulse_init();
    @(negedge clk); ecc_init = 1'b1;
    @(negedge clk); ecc_init = 1'b0;
  endtask

  task automatic load(input logic [31:0] w);
    @(negedge clk); cmp_lo_wr = 1'b1; cmp_half = w[15:0];
    @(negedge clk); cmp_lo_wr = 1'b0; cmp_hi_wr = 1'b1; cmp_half = w[31:16];
    @(negedge clk); cmp_hi_wr = 1'b0;
  endtask

  logic [31:0] golden, held;

  initial begin
    repeat (3) @(negedge clk);
    chk(parity_word == 32'h0 && stat_valid == 1'b0 && stat_word == 18'h0, "R1 reset state",
        {13'h0, stat_valid, stat_word}, 32'h0);
    rst_n = 1'b1;

    // Clean step, then compare with itself.
    pulse_init();
    feed(0, 512, 1, -1, 0, -1, 0, 1'b1);
    golden = parity_word;
    chk(golden[31:24] == 8'h00, "R4 top byte zero", golden, golden & 32'h00FF_FFFF);
    load(golden);
    chk(stat_valid && stat_word == 18'h0, "R6 clean compare", 32'(stat_word), 32'h0);

    // Single data bit flips at interior and edge positions.
    pulse_init();
    feed(0, 512, 1, 300, 5, -1, 0, 1'b0);
    load(golden);
    chk(stat_word == {2'b00, 9'd300, 3'd5, 2'b00, 2'b01}, "R7 byte 300 bit 5",
        32'(stat_word), 32'({2'b00, 9'd300, 3'd5, 2'b00, 2'b01}));
    pulse_init();
    feed(0, 512, 1, 0, 0, -1, 0, 1'b0);
    load(golden);
    chk(stat_word == 18'h1, "R7 byte 0 bit 0", 32'(stat_word), 32'h1);
    pulse_init();
    feed(0, 512, 1, 511, 7, -1, 0, 1'b1);
    load(golden);
    chk(stat_word == {2'b00, 9'd511, 3'd7, 2'b00, 2'b01}, "R7 byte 511 bit 7",
        32'(stat_word), 32'({2'b00, 9'd511, 3'd7, 2'b00, 2'b01}));

    // Stored parity with one bit wrong.
    pulse_init();
    feed(0, 512, 1, -1, 0, -1, 0, 1'b0);
    load(golden ^ 32'h0000_2000);
    chk(stat_word == 18'h3, "R8 stored bit 13 flipped", 32'(stat_word), 32'h3);
    load(golden ^ 32'h0400_0000);
    chk(stat_word == 18'h3, "R8 stored bit 26 flipped", 32'(stat_word), 32'h3);

    // Multi-bit errors.
    load(golden ^ 32'h0000_0003);
    chk(stat_word == 18'h2, "R9 pair both set", 32'(stat_word), 32'h2);
    pulse_init();
    feed(0, 512, 1, 17, 2, 400, 6, 1'b0);
    load(golden);
    chk(stat_word == 18'h2, "R9 two data flips", 32'(stat_word), 32'h2);

    // Low-half write clears valid.
    @(negedge clk); cmp_lo_wr = 1'b1; cmp_half = golden[15:0];
    @(negedge clk); cmp_lo_wr = 1'b0;
    chk(stat_valid == 1'b0, "R5 low write clears valid", 32'(stat_valid), 32'h0);

    // Lock holds accumulator and counter.
    pulse_init();
    feed(0, 200, 1, -1, 0, -1, 0, 1'b0);
    held = parity_word;
    @(negedge clk); ecc_lock = 1'b1;
    feed(0, 50, 9, -1, 0, -1, 0, 1'b0);
    chk(parity_word == held, "R3 locked bytes ignored", parity_word, held);
    @(negedge clk); ecc_lock = 1'b0;
    feed(200, 312, 1, -1, 0, -1, 0, 1'b1);
    chk(parity_word == golden, "R3 counter resumed", parity_word, golden);

    // Wrap: the same 512 bytes again cancel out.
    feed(0, 512, 1, -1, 0, -1, 0, 1'b0);
    chk(parity_word == 32'h0, "R4 counter wraps at 512", parity_word, 32'h0);

    // Init mid-step, and init colliding with a byte.
    feed(0, 40, 3, -1, 0, -1, 0, 1'b0);
    @(negedge clk); ecc_init = 1'b1; byte_vld = 1'b1; byte_data = 8'hFF;
    @(negedge clk); ecc_init = 1'b0; byte_vld = 1'b0;
    chk(parity_word == 32'h0, "R2 init clears and drops byte", parity_word, 32'h0);
    feed(0, 512, 1, -1, 0, -1, 0, 1'b0);
    chk(parity_word == golden, "R2 counter restarted", parity_word, golden);
    load(golden);
    pulse_init();
    chk(stat_valid == 1'b0, "R5 init clears valid", 32'(stat_valid), 32'h0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule